// File: doc/BRIEF.md
# Multidimensional cache lookup unit

This block performs the tag lookup for a software-managed cache whose blocks are laid out in one to four dimensions. The cache is indexed with array indices, not with a flat address. One request carries two 128-bit operands. The first holds four 32-bit indices, one per dimension. The second holds the packed geometry of the cache:
- the base line of the tag array in local store,
- the set mask,
- for each dimension, a shift, a cumulative tag bound and a cumulative block span.

From these the unit hashes the set, assembles the tag and computes the byte offset inside the block. It then fetches one tag line from local store through a read port with a fixed latency and compares the four stored tags against the computed tag.

Each lookup returns a hit flag, the matching way, the set, the tag and the data position. Software handles every miss: the unit refills nothing, replaces nothing and moves no data. The lookup is fully pipelined, so one request can be accepted in every cycle. Each request produces a one-cycle result pulse a fixed number of cycles later, and results come out in request order.

Top module: `mdlk_unit`

## Requirements
- R1: While `rst` is high, `req_ready`, `ls_rd_en` and `res_valid` are low. `req_ready` is high from the first clock edge after reset is released. In the cycle after reset is released, neither a read nor a result is produced.
- R2: Index layout: X = `req_idx[31:0]`, Y = `[63:32]`, Z = `[95:64]`, W = `[127:96]`; dimension 0 is X and dimension 3 is W. The geometry operand holds:
  - the shift of dimension d in `req_cfg[24+8d +: 8]`,
  - the set mask (number of sets minus one) in `req_cfg[23:16]`.

  Per dimension, the block coordinate c = index >> shift contributes c ^ (index >> (shift+1)). The set is the low 8 bits of the 32-bit sum of these four terms, ANDed with the set mask.
- R3: The tag bound of dimension d sits in `req_cfg[56+8d +: 8]` and is cumulative. The tag places the low (bound[d] − bound[d−1]) bits of the block coordinate of dimension d at bit position bound[d−1], with bound[−1] = 0.
- R4: The tag array base (a 16-byte line number) is in `req_cfg[15:0]`. In the cycle after each accepted request, `ls_rd_en` is high with `ls_rd_addr` = base + set. No read is issued in a cycle that follows a cycle without an accepted request.
- R5: The fetched line holds way w in bits [32w+31:32w]. A way hits when its tag equals the computed tag and is not all ones. If several ways match, the lowest matching way is reported. A computed tag of all ones never hits.
- R6: The block span of dimension d sits in `req_cfg[88+8d +: 8]` and is cumulative. The offset places the low shift[d] bits of index d at bit position span[d−1], with span[−1] = 0. On a hit, `res_pos` = ((set·4 + way) << span[3]) + offset.
- R7: On a miss, `res_hit` is 0, `res_way` is 0, `res_pos` equals the offset alone, and `res_set` and `res_tag` still carry the computed set and tag.
- R8: With read latency L, the result of a request accepted at clock edge k is presented on the outputs after edge k+L+1, with `res_valid` high for exactly one cycle. Back-to-back requests yield back-to-back results in request order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can accept a request |
| req_idx | input | 128 | Four 32-bit indices, X in the low word |
| req_cfg | input | 128 | Packed cache geometry |
| ls_rd_en | output | 1 | Tag-line read strobe to local store |
| ls_rd_addr | output | 16 | Tag-line number to read |
| ls_rd_data | input | 128 | Tag line, RD_LAT cycles after the strobe |
| res_valid | output | 1 | One-cycle pulse per finished lookup |
| res_hit | output | 1 | Tag found in a valid way |
| res_way | output | 2 | Matching way, 0 on a miss |
| res_pos | output | 32 | Data position in the cache storage |
| res_tag | output | 32 | Computed tag |
| res_set | output | 8 | Computed set |

## Verification
The first pattern is a full sweep of every X and Y index in a two-dimensional geometry with four sets. It covers every in-block offset against every block coordinate. It also separates hits from misses, because only part of the blocks are preloaded. A one-dimensional geometry with a hand-built tag line tells the lowest-way priority apart from a later duplicate. In the same geometry, an all-ones tag is matched against an all-ones entry. A four-dimensional geometry driven with pseudo-random wide indices is the third pattern. Its upper bits must be discarded by the tag bounds, and its hash sums carry across bytes. Idle gaps are mixed into the stream, which shows that reads and results follow only accepted requests.

// File: rtl/mdlk_pkg.sv
package mdlk_pkg;
    localparam int NDIM   = 4;
    localparam int IDX_W  = 32;
    localparam int PRM_W  = 8;
    localparam int LS_AW  = 16;
    localparam int WAYS   = 4;
    localparam int TAG_W  = 32;
    localparam int POS_W  = 32;
    localparam int WAY_W  = $clog2(WAYS);
    localparam int LINE_W = WAYS * TAG_W;
    localparam int OPND_W = NDIM * IDX_W;

    typedef logic [NDIM-1:0][IDX_W-1:0] idx_vec_t;

    // geometry operand, low bits first: base, set mask, shifts, bounds, spans
    typedef struct packed {
        logic [NDIM-1:0][PRM_W-1:0] span;
        logic [NDIM-1:0][PRM_W-1:0] bound;
        logic [NDIM-1:0][PRM_W-1:0] shift;
        logic [PRM_W-1:0]           set_mask;
        logic [LS_AW-1:0]           tag_base;
    } lk_cfg_t;

    typedef struct packed {
        logic [TAG_W-1:0] tag;
        logic [PRM_W-1:0] set;
        logic [POS_W-1:0] offset;
        logic [PRM_W-1:0] blk_log2;
    } lk_meta_t;

    localparam int CFG_W = $bits(lk_cfg_t);

    function automatic logic [IDX_W-1:0] ones_below(input logic [PRM_W-1:0] n);
        if (n >= PRM_W'(IDX_W))
            ones_below = '1;
        else
            ones_below = (IDX_W'(1) << n) - IDX_W'(1);
    endfunction
endpackage

// File: rtl/mdlk_index_calc.sv
module mdlk_index_calc
    import mdlk_pkg::*;
(
    input  idx_vec_t         idx,
    input  lk_cfg_t          cfg,
    output lk_meta_t         meta,
    output logic [LS_AW-1:0] rd_addr
);
    logic [NDIM-1:0][IDX_W-1:0] hash_t;
    logic [NDIM-1:0][IDX_W-1:0] tag_f;
    logic [NDIM-1:0][IDX_W-1:0] off_f;

    for (genvar d = 0; d < NDIM; d++) begin : g_dim
        logic [PRM_W-1:0] tag_lo;
        logic [PRM_W-1:0] off_lo;
        logic [PRM_W:0]   sh_next;
        logic [IDX_W-1:0] coord;

        if (d == 0) begin : g_first
            assign tag_lo = '0;
            assign off_lo = '0;
        end else begin : g_upper
            assign tag_lo = cfg.bound[d-1];
            assign off_lo = cfg.span[d-1];
        end

        assign coord     = idx[d] >> cfg.shift[d];
        assign sh_next   = {1'b0, cfg.shift[d]} + (PRM_W+1)'(1);
        assign hash_t[d] = coord ^ (idx[d] >> sh_next);
        assign tag_f[d]  = (coord & ones_below(cfg.bound[d] - tag_lo)) << tag_lo;
        assign off_f[d]  = (idx[d] & ones_below(cfg.shift[d])) << off_lo;
    end

    logic [IDX_W-1:0] hsum;
    logic [TAG_W-1:0] tag_c;
    logic [POS_W-1:0] off_c;

    always_comb begin
        hsum  = '0;
        tag_c = '0;
        off_c = '0;
        for (int i = 0; i < NDIM; i++) begin
            hsum  = hsum + hash_t[i];
            tag_c = tag_c | tag_f[i];
            off_c = off_c | off_f[i];
        end
    end

    assign meta.set      = hsum[PRM_W-1:0] & cfg.set_mask;
    assign meta.tag      = tag_c;
    assign meta.offset   = off_c;
    assign meta.blk_log2 = cfg.span[NDIM-1];
    assign rd_addr       = cfg.tag_base + LS_AW'(meta.set);
endmodule

// File: rtl/mdlk_delay.sv
module mdlk_delay #(
    parameter int W     = 8,
    parameter int DEPTH = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    if (DEPTH == 0) begin : g_wire
        assign dout = din;
    end else begin : g_regs
        logic [W-1:0] stg [DEPTH];
        always_ff @(posedge clk) begin
            if (rst) begin
                for (int i = 0; i < DEPTH; i++) stg[i] <= '0;
            end else begin
                stg[0] <= din;
                for (int i = 1; i < DEPTH; i++) stg[i] <= stg[i-1];
            end
        end
        assign dout = stg[DEPTH-1];
    end
endmodule

// File: rtl/mdlk_way_match.sv
module mdlk_way_match
    import mdlk_pkg::*;
(
    input  logic [LINE_W-1:0] line,
    input  logic [TAG_W-1:0]  tag,
    output logic              hit,
    output logic [WAY_W-1:0]  way
);
    logic [WAYS-1:0] eq;

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        logic [TAG_W-1:0] stored;
        assign stored = line[w*TAG_W +: TAG_W];
        assign eq[w]  = (stored == tag) && (stored != '1);
    end

    always_comb begin
        hit = |eq;
        way = '0;
        for (int w = WAYS - 1; w >= 0; w--)
            if (eq[w]) way = WAY_W'(w);
    end
endmodule

// File: rtl/mdlk_unit.sv
module mdlk_unit
    import mdlk_pkg::*;
#(
    parameter int RD_LAT = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [OPND_W-1:0] req_idx,
    input  logic [OPND_W-1:0] req_cfg,
    output logic              ls_rd_en,
    output logic [LS_AW-1:0]  ls_rd_addr,
    input  logic [LINE_W-1:0] ls_rd_data,
    output logic              res_valid,
    output logic              res_hit,
    output logic [WAY_W-1:0]  res_way,
    output logic [POS_W-1:0]  res_pos,
    output logic [TAG_W-1:0]  res_tag,
    output logic [PRM_W-1:0]  res_set
);
    localparam int META_W = $bits(lk_meta_t);

    logic ready_q;
    logic accept;
    assign req_ready = ready_q;
    assign accept    = req_valid & ready_q;

    logic unused_cfg_bits;
    assign unused_cfg_bits = ^req_cfg[OPND_W-1:CFG_W];

    lk_meta_t         calc_meta, s1_meta, al_meta;
    logic [LS_AW-1:0] calc_addr, s1_addr;
    logic             s1_v, al_v;

    mdlk_index_calc u_calc (
        .idx     (idx_vec_t'(req_idx)),
        .cfg     (lk_cfg_t'(req_cfg[CFG_W-1:0])),
        .meta    (calc_meta),
        .rd_addr (calc_addr)
    );

    // stage 1: computed fields held while the tag line is requested
    always_ff @(posedge clk) begin
        if (rst) begin
            ready_q <= 1'b0;
            s1_v    <= 1'b0;
            s1_meta <= '0;
            s1_addr <= '0;
        end else begin
            ready_q <= 1'b1;
            s1_v    <= accept;
            if (accept) begin
                s1_meta <= calc_meta;
                s1_addr <= calc_addr;
            end
        end
    end

    assign ls_rd_en   = s1_v;
    assign ls_rd_addr = s1_addr;

    // metadata travels alongside the local-store read
    logic [META_W:0] al_bus;
    mdlk_delay #(.W(META_W + 1), .DEPTH(RD_LAT)) u_align (
        .clk  (clk),
        .rst  (rst),
        .din  ({s1_v, s1_meta}),
        .dout (al_bus)
    );
    assign al_v    = al_bus[META_W];
    assign al_meta = al_bus[META_W-1:0];

    logic             mw_hit;
    logic [WAY_W-1:0] mw_way;
    mdlk_way_match u_match (
        .line (ls_rd_data),
        .tag  (al_meta.tag),
        .hit  (mw_hit),
        .way  (mw_way)
    );

    logic [POS_W-1:0] blk_index, blk_addr, pos_c;
    assign blk_index = POS_W'({al_meta.set, mw_way});
    assign blk_addr  = blk_index << al_meta.blk_log2;
    assign pos_c     = mw_hit ? blk_addr + al_meta.offset : al_meta.offset;

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            res_hit   <= 1'b0;
            res_way   <= '0;
            res_pos   <= '0;
            res_tag   <= '0;
            res_set   <= '0;
        end else begin
            res_valid <= al_v;
            if (al_v) begin
                res_hit <= mw_hit;
                res_way <= mw_way;
                res_pos <= pos_c;
                res_tag <= al_meta.tag;
                res_set <= al_meta.set;
            end
        end
    end
endmodule

// File: rtl/mdlk_unit_chk.sv
module mdlk_unit_chk #(
    parameter int RD_LAT = 6
) (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        req_ready,
    input logic        ls_rd_en,
    input logic        res_valid,
    input logic        res_hit,
    input logic [1:0]  res_way,
    input logic [31:0] res_tag
);
    localparam int CNT_W = $clog2(RD_LAT + 4) + 1;

    logic             acc;
    logic [CNT_W-1:0] inflight_q;
    assign acc = req_valid && req_ready;

    always_ff @(posedge clk) begin
        if (rst)
            inflight_q <= '0;
        else
            inflight_q <= inflight_q + CNT_W'(acc) - CNT_W'(res_valid);
    end

    p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!res_valid && !ls_rd_en));

    p_read_on_accept_r4: assert property (@(posedge clk) disable iff (rst)
        acc |=> ls_rd_en);

    p_no_read_when_idle_r4: assert property (@(posedge clk) disable iff (rst)
        !acc |=> !ls_rd_en);

    p_ones_never_hit_r5: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_hit) |-> (res_tag != 32'hFFFF_FFFF));

    p_miss_way_zero_r7: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !res_hit) |-> (res_way == 2'd0));

    p_result_has_request_r8: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> (inflight_q != '0));

    p_inflight_bound_r8: assert property (@(posedge clk) disable iff (rst)
        inflight_q <= CNT_W'(RD_LAT + 2));
endmodule

bind mdlk_unit mdlk_unit_chk #(.RD_LAT(RD_LAT)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .ls_rd_en  (ls_rd_en),
    .res_valid (res_valid),
    .res_hit   (res_hit),
    .res_way   (res_way),
    .res_tag   (res_tag)
);

// File: tb/mdlk_unit_tb.sv
`timescale 1ns/1ps
module mdlk_unit_tb;
    localparam int LAT = 6;

    logic         clk = 1'b0;
    logic         rst;
    logic         req_valid;
    logic         req_ready;
    logic [127:0] req_idx;
    logic [127:0] req_cfg;
    logic         ls_rd_en;
    logic [15:0]  ls_rd_addr;
    logic [127:0] ls_rd_data;
    logic         res_valid;
    logic         res_hit;
    logic [1:0]   res_way;
    logic [31:0]  res_pos;
    logic [31:0]  res_tag;
    logic [7:0]   res_set;

    always #4 clk = ~clk;

    mdlk_unit #(.RD_LAT(LAT)) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_idx(req_idx), .req_cfg(req_cfg), .ls_rd_en(ls_rd_en),
        .ls_rd_addr(ls_rd_addr), .ls_rd_data(ls_rd_data), .res_valid(res_valid),
        .res_hit(res_hit), .res_way(res_way), .res_pos(res_pos),
        .res_tag(res_tag), .res_set(res_set)
    );

    // local-store model with fixed read latency
    logic [127:0] mem [64];
    logic [15:0]  aq  [LAT];
    always @(posedge clk) begin
        aq[0] <= ls_rd_addr;
        for (int i = 1; i < LAT; i++) aq[i] <= aq[i-1];
    end
    assign ls_rd_data = mem[aq[LAT-1][5:0]];

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int n_acc  = 0;
    int n_rd   = 0;
    bit done   = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [127:0] mkcfg(input logic [15:0] base, input logic [7:0] smask,
                                           input logic [31:0] sh, input logic [31:0] bd,
                                           input logic [31:0] sp);
        return {8'h00, sp, bd, sh, smask, base};
    endfunction

    function automatic logic [63:0] lowmask(input int n);
        if (n >= 64) return '1;
        return (64'd1 << n) - 64'd1;
    endfunction

    function automatic void model(input logic [127:0] idx, input logic [127:0] cfg,
                                  output logic [7:0] set, output logic [31:0] tag,
                                  output logic [31:0] off, output logic [7:0] lg,
                                  output logic [15:0] addr);
        logic [31:0] hsum;
        logic [63:0] t, o;
        int tlo, olo;
        hsum = 0; t = 0; o = 0; tlo = 0; olo = 0;
        for (int d = 0; d < 4; d++) begin
            logic [63:0] v, c, c1;
            int s, b, p;
            v  = {32'd0, idx[32*d +: 32]};
            s  = int'(cfg[24 + 8*d +: 8]);
            b  = int'(cfg[56 + 8*d +: 8]);
            p  = int'(cfg[88 + 8*d +: 8]);
            c  = (s >= 64) ? 64'd0 : v >> s;
            c1 = (s + 1 >= 64) ? 64'd0 : v >> (s + 1);
            hsum = hsum + 32'(c ^ c1);
            if (tlo < 32) t = t | ((c & lowmask(b - tlo)) << tlo);
            if (olo < 32) o = o | ((v & lowmask(s)) << olo);
            tlo = b;
            olo = p;
        end
        set  = hsum[7:0] & cfg[23:16];
        tag  = t[31:0];
        off  = o[31:0];
        lg   = cfg[119:112];
        addr = cfg[15:0] + {8'd0, set};
    endfunction

    typedef struct packed {
        logic        hit;
        logic [1:0]  way;
        logic [7:0]  set;
        logic [31:0] tag;
        logic [31:0] pos;
        logic [31:0] acc;
    } exp_t;

    exp_t        eq_q[$];
    logic [15:0] aq_q[$];

    // monitor: samples away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            if (ls_rd_en) begin
                n_rd++;
                if (aq_q.size() == 0)
                    chk(0, "R4", "read without request", 64'(ls_rd_addr), 64'h0);
                else
                    chk(ls_rd_addr == aq_q[0], "R4", "read address", 64'(ls_rd_addr), 64'(aq_q[0]));
                if (aq_q.size() != 0) void'(aq_q.pop_front());
            end
            if (res_valid) begin
                if (eq_q.size() == 0) begin
                    chk(0, "R8", "result without request", 64'(res_tag), 64'h0);
                end else begin
                    exp_t e;
                    e = eq_q.pop_front();
                    chk(res_hit == e.hit, "R5", "hit", 64'(res_hit), 64'(e.hit));
                    chk(res_way == e.way, e.hit ? "R5" : "R7", "way", 64'(res_way), 64'(e.way));
                    chk(res_set == e.set, "R2", "set", 64'(res_set), 64'(e.set));
                    chk(res_tag == e.tag, "R3", "tag", 64'(res_tag), 64'(e.tag));
                    chk(res_pos == e.pos, e.hit ? "R6" : "R7", "position", 64'(res_pos), 64'(e.pos));
                    chk(cyc == int'(e.acc) + LAT + 1, "R8", "latency", 64'(cyc), 64'(e.acc + LAT + 1));
                end
            end
            if (req_valid && req_ready) begin
                logic [7:0]  s, lg;
                logic [31:0] t, o;
                logic [15:0] a;
                logic [127:0] line;
                exp_t e;
                model(req_idx, req_cfg, s, t, o, lg, a);
                line  = mem[a[5:0]];
                e.hit = 1'b0;
                e.way = 2'd0;
                for (int w = 3; w >= 0; w--)
                    if (line[32*w +: 32] == t && t != 32'hFFFF_FFFF) begin
                        e.hit = 1'b1;
                        e.way = 2'(w);
                    end
                e.set = s;
                e.tag = t;
                e.pos = e.hit ? ((32'({s, e.way})) << lg) + o : o;
                e.acc = 32'(cyc + 1);
                eq_q.push_back(e);
                aq_q.push_back(a);
                n_acc++;
            end
        end
    end

    task automatic drive(input logic [127:0] idx, input logic [127:0] cfg);
        @(posedge clk); #1;
        req_valid = 1'b1;
        req_idx   = idx;
        req_cfg   = cfg;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            req_valid = 1'b0;
        end
    endtask

    task automatic fill(input logic [127:0] idx, input logic [127:0] cfg);
        logic [7:0]  s, lg;
        logic [31:0] t, o;
        logic [15:0] a;
        bit placed;
        model(idx, cfg, s, t, o, lg, a);
        placed = 0;
        for (int w = 0; w < 4; w++)
            if (!placed && mem[a[5:0]][32*w +: 32] == t) placed = 1;
        for (int w = 0; w < 4; w++)
            if (!placed && mem[a[5:0]][32*w +: 32] == 32'hFFFF_FFFF) begin
                mem[a[5:0]][32*w +: 32] = t;
                placed = 1;
            end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    logic [127:0] cfg2, cfg1, cfg4;
    logic [127:0] pool [40];
    logic [31:0]  lcg;

    initial begin
        rst       = 1'b1;
        req_valid = 1'b0;
        req_idx   = '0;
        req_cfg   = '0;
        for (int i = 0; i < 64; i++) mem[i] = '1;

        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(req_ready == 1'b0, "R1", "ready in reset", 64'(req_ready), 64'h0);
        chk(res_valid == 1'b0, "R1", "result in reset", 64'(res_valid), 64'h0);
        chk(ls_rd_en == 1'b0, "R1", "read in reset", 64'(ls_rd_en), 64'h0);
        @(posedge clk); #1;
        rst = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk(req_ready == 1'b1, "R1", "ready after reset", 64'(req_ready), 64'h1);
        chk(res_valid == 1'b0 && ls_rd_en == 1'b0, "R1", "quiet after reset",
            64'({res_valid, ls_rd_en}), 64'h0);

        // two-dimensional sweep, four sets, part of the blocks preloaded
        cfg2 = mkcfg(16'd16, 8'd3, 32'h0000_0202, 32'h0707_0704, 32'h0404_0402);
        for (int by = 0; by < 8; by++)
            for (int bx = 0; bx < 16; bx++)
                if (((by * 16 + bx) % 3) != 0)
                    fill({64'd0, 32'(by * 4), 32'(bx * 4)}, cfg2);
        for (int y = 0; y < 32; y++)
            for (int x = 0; x < 64; x++) begin
                drive({64'd0, 32'(y), 32'(x)}, cfg2);
                if (((y * 64 + x) % 37) == 5) idle(2);
            end
        idle(LAT + 4);

        // one-dimensional geometry: priority among ways and the all-ones entry
        cfg1 = mkcfg(16'd40, 8'd0, 32'h0, 32'h2020_2020, 32'h0);
        mem[40] = {32'h0000_0A5A, 32'h0000_0B0B, 32'h0000_0A5A, 32'hFFFF_FFFF};
        drive({96'd0, 32'h0000_0A5A}, cfg1);   // R5: way1 and way3 match, way1 expected
        drive({96'd0, 32'h0000_0B0B}, cfg1);
        drive({96'd0, 32'hFFFF_FFFF}, cfg1);   // R5: all-ones tag must miss
        drive({96'd0, 32'h0000_1234}, cfg1);   // R7: plain miss
        idle(LAT + 4);

        // four-dimensional geometry with wide pseudo-random indices
        cfg4 = mkcfg(16'd48, 8'd7, 32'h0101_0101, 32'h0C09_0603, 32'h0403_0201);
        lcg = 32'h1357_9BDF;
        for (int i = 0; i < 40; i++) begin
            for (int d = 0; d < 4; d++) begin
                lcg = lcg * 32'd1664525 + 32'd1013904223;
                pool[i][32*d +: 32] = lcg;
            end
            fill(pool[i], cfg4);
        end
        for (int i = 0; i < 400; i++) begin
            logic [127:0] v;
            if ((i % 2) == 0) begin
                v = pool[(i * 7) % 40];
            end else begin
                for (int d = 0; d < 4; d++) begin
                    lcg = lcg * 32'd1664525 + 32'd1013904223;
                    v[32*d +: 32] = lcg;
                end
            end
            drive(v, cfg4);
            if ((i % 29) == 3) idle(1);
        end
        idle(LAT + 6);

        @(negedge clk);
        chk(eq_q.size() == 0, "R8", "results outstanding", 64'(eq_q.size()), 64'h0);
        chk(n_rd == n_acc, "R4", "reads per accepted request", 64'(n_rd), 64'(n_acc));
        finish_run();
    end
endmodule